// File: doc/BRIEF.md
# Column-Interleaved Parallel Word Multiplier

This block multiplies two wide unsigned integers, each made of `N_WORDS` words of `WORD_W` bits, and returns the full double-length product as a stream of words, least significant first. It uses product-scanning order. Every output column, meaning the set of word products whose indices add up to the same value, is summed by one of `N_WORDS` multiply-accumulate lanes. Columns are handed out to lanes round-robin. Their start times are staggered so that column `k` completes in issue cycle `k`. The multiply phase therefore takes about `2*N_WORDS` cycles rather than `N_WORDS²`.

A registered selector picks the lane that holds the column just completed. A merge accumulator then adds that column sum to the carry left over from the previous column. It emits the low word and keeps the rest, shifted down by one word, as the next carry. After the last column, the remaining carry is sent out as the top word. The operands are loaded in parallel on a start strobe. A field-arithmetic engine would feed the word stream into a separate reduction stage.

Top module: `comba_mul_top`

## Requirements
- R1: After reset, `busy` and `prod_valid` are 0.
- R2: The words presented with `prod_valid` high, in order, are words 0 through `2*N_WORDS-1` of the exact product `a_in * b_in`. Word `k` is product bits `[k*WORD_W +: WORD_W]`.
- R3: `start` is sampled when `busy` is 0. Word 0 appears with `prod_valid` high after the fourth rising edge that follows the sampling edge. `prod_valid` stays low after the three edges before that.
- R4: The words arrive on consecutive cycles. `prod_last` is 1 only together with the top word, number `2*N_WORDS-1`, and `prod_valid` is 0 in the cycle after it.
- R5: `busy` is 1 from the sampling edge until one edge after the top word. While `busy` is 1, `start` and the operand inputs have no effect: the running product is unchanged and no second product stream follows.
- R6: Operands with every bit set, and operands of zero, give exact results. The column carry is never lost.
- R7: A new `start` is accepted in the first cycle that `busy` is 0 again, and its product is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a product; sampled only when idle |
| a_in | input | N_WORDS*WORD_W | Multiplicand, word 0 in the low bits |
| b_in | input | N_WORDS*WORD_W | Multiplier, word 0 in the low bits |
| busy | output | 1 | A product is in progress |
| prod_valid | output | 1 | `prod_word` carries a product word |
| prod_word | output | WORD_W | Current product word, least significant first |
| prod_last | output | 1 | Marks the top product word |

## Verification
The hardest case to reach from the ports is a column sum that fills the merge accumulator to its top bit while a full carry arrives from the column below. This case exercises the width chosen for the carry path. Operands with every bit set produce it in the middle columns, and random operands with near-full words cover nearby patterns. The other case is a strobe that arrives mid-run with different operands. The bench pulses `start` with inverted operands while the lanes are busy. It then checks that the stream is unchanged and that nothing follows the top word, and it restarts in the exact cycle that `busy` falls.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    localparam int TAG_IDX_W = 8;

    // column tag travelling alongside the lane pipeline
    typedef struct packed {
        logic                 vld;
        logic [TAG_IDX_W-1:0] col;
    } col_tag_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } ctl_state_t;

    // lane that owns column col when columns are dealt round-robin
    function automatic int lane_for_col(input int col, input int lanes);
        return (col < lanes) ? col : col - lanes;
    endfunction

endpackage

// File: rtl/cmul_lane.sv
module cmul_lane
    import cmul_pkg::*;
#(
    parameter int LANE    = 0,
    parameter int N_WORDS = 16,
    parameter int WORD_W  = 16,
    parameter int ACC_W   = 36,
    parameter int CYC_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue,
    input  logic [CYC_W-1:0]          cyc,
    input  logic [N_WORDS*WORD_W-1:0] a_vec,
    input  logic [N_WORDS*WORD_W-1:0] b_vec,
    output logic [ACC_W-1:0]          col_sum
);
    // low column LANE runs in cycles 0..LANE,
    // high column LANE+N_WORDS runs in cycles 2*LANE+2..LANE+N_WORDS
    localparam int HI_START = 2 * LANE + 2;
    localparam int HI_END   = LANE + N_WORDS;
    localparam bit HAS_HI   = (LANE <= N_WORDS - 2);

    logic act, first;
    int   ai, bj;

    always_comb begin
        act   = 1'b0;
        first = 1'b0;
        ai    = 0;
        bj    = 0;
        if (issue) begin
            if (int'(cyc) <= LANE) begin
                act   = 1'b1;
                first = (cyc == '0);
                ai    = int'(cyc);
                bj    = LANE - int'(cyc);
            end else if (HAS_HI && int'(cyc) >= HI_START && int'(cyc) <= HI_END) begin
                act   = 1'b1;
                first = (int'(cyc) == HI_START);
                ai    = int'(cyc) - LANE - 1;
                bj    = 2 * LANE + N_WORDS + 1 - int'(cyc);
            end
        end
    end

    logic [WORD_W-1:0]   op_a_q, op_b_q;
    logic                act_q, first_q;
    logic [2*WORD_W-1:0] prod;

    // input register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            op_a_q  <= '0;
            op_b_q  <= '0;
            act_q   <= 1'b0;
            first_q <= 1'b0;
        end else begin
            op_a_q  <= act ? a_vec[ai*WORD_W +: WORD_W] : '0;
            op_b_q  <= act ? b_vec[bj*WORD_W +: WORD_W] : '0;
            act_q   <= act;
            first_q <= first;
        end
    end

    assign prod = op_a_q * op_b_q;

    // multiply-accumulate, cleared on the first term of each column
    always_ff @(posedge clk) begin
        if (rst) begin
            col_sum <= '0;
        end else if (act_q) begin
            col_sum <= first_q ? ACC_W'(prod) : col_sum + ACC_W'(prod);
        end
    end

endmodule

// File: rtl/cmul_merge.sv
module cmul_merge
    import cmul_pkg::*;
#(
    parameter int N_WORDS = 16,
    parameter int WORD_W  = 16,
    parameter int ACC_W   = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  col_tag_t          tag_in,
    input  logic [ACC_W-1:0]  lane_sums [N_WORDS],
    output logic              out_vld,
    output logic              out_last,
    output logic [WORD_W-1:0] out_word
);
    localparam int LAST_COL = 2 * N_WORDS - 2;
    localparam int SEL_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    col_tag_t          tag_q;
    logic [ACC_W-1:0]  pick_q, acc_q, sum_next;
    logic [SEL_W-1:0]  sel;
    logic              top_pend;

    assign sel      = SEL_W'(lane_for_col(int'(tag_in.col), N_WORDS));
    assign sum_next = pick_q + ((tag_q.col == '0) ? '0 : (acc_q >> WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q    <= '0;
            pick_q   <= '0;
            acc_q    <= '0;
            top_pend <= 1'b0;
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            out_word <= '0;
        end else begin
            tag_q    <= tag_in;
            if (tag_in.vld) pick_q <= lane_sums[sel];
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            top_pend <= 1'b0;
            if (tag_q.vld) begin
                acc_q    <= sum_next;
                out_word <= sum_next[WORD_W-1:0];
                out_vld  <= 1'b1;
                top_pend <= (int'(tag_q.col) == LAST_COL);
            end else if (top_pend) begin
                out_word <= acc_q[2*WORD_W-1:WORD_W];
                out_vld  <= 1'b1;
                out_last <= 1'b1;
            end
        end
    end

    // R2: columns reach the merge stage in strictly ascending order
    col_order_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_q.vld && tag_q.col != '0) |->
            ($past(tag_q.vld) && tag_q.col == TAG_IDX_W'($past(tag_q.col) + 1'b1)));

endmodule

// File: rtl/comba_mul_top.sv
module comba_mul_top
    import cmul_pkg::*;
#(
    parameter int N_WORDS = 16,
    parameter int WORD_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [N_WORDS*WORD_W-1:0] a_in,
    input  logic [N_WORDS*WORD_W-1:0] b_in,
    output logic                      busy,
    output logic                      prod_valid,
    output logic [WORD_W-1:0]         prod_word,
    output logic                      prod_last
);
    localparam int ACC_W    = 2 * WORD_W + $clog2(N_WORDS);
    localparam int CYC_W    = $clog2(2 * N_WORDS);
    localparam int LAST_COL = 2 * N_WORDS - 2;

    ctl_state_t                state;
    logic [CYC_W-1:0]          cyc;
    logic [N_WORDS*WORD_W-1:0] a_q, b_q;
    logic                      issue;
    col_tag_t                  tag_d1, tag_d2;
    logic [ACC_W-1:0]          lane_sums [N_WORDS];

    assign issue = (state == ST_ISSUE);
    assign busy  = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cyc   <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    a_q   <= a_in;
                    b_q   <= b_in;
                    cyc   <= '0;
                    state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (int'(cyc) == LAST_COL) state <= ST_DRAIN;
                    else                       cyc   <= cyc + 1'b1;
                end
                ST_DRAIN: if (prod_last) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // tag delay matches the lane input register and accumulator
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_d1 <= '0;
            tag_d2 <= '0;
        end else begin
            tag_d1 <= '{vld: issue, col: TAG_IDX_W'(cyc)};
            tag_d2 <= tag_d1;
        end
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_lane
        cmul_lane #(
            .LANE(g), .N_WORDS(N_WORDS), .WORD_W(WORD_W),
            .ACC_W(ACC_W), .CYC_W(CYC_W)
        ) u_lane (
            .clk(clk), .rst(rst), .issue(issue), .cyc(cyc),
            .a_vec(a_q), .b_vec(b_q), .col_sum(lane_sums[g])
        );
    end

    cmul_merge #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .ACC_W(ACC_W)) u_merge (
        .clk(clk), .rst(rst), .tag_in(tag_d2), .lane_sums(lane_sums),
        .out_vld(prod_valid), .out_last(prod_last), .out_word(prod_word)
    );

    // R5
    opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(a_q) && $stable(b_q)));

    // R4
    last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        prod_last |-> (prod_valid && busy));

    // R4
    quiet_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        prod_last |=> !prod_valid);

endmodule

// File: tb/tb_comba_mul_top.sv
`timescale 1ns/1ps
module tb_comba_mul_top;
    localparam int N  = 16;
    localparam int W  = 16;
    localparam int NW = N * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NW-1:0] a_in = '0, b_in = '0;
    logic          busy, prod_valid, prod_last;
    logic [W-1:0]  prod_word;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    comba_mul_top #(.N_WORDS(N), .WORD_W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy), .prod_valid(prod_valid), .prod_word(prod_word),
        .prod_last(prod_last)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NW-1:0] rnd_opnd(input int bias);
        logic [NW-1:0] v;
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] w;
            w = W'($urandom);
            if (bias == 1) w = w | 16'hFF00;
            v[i*W +: W] = w;
        end
        return v;
    endfunction

    // called at a falling edge; returns at the falling edge where busy is low again
    task automatic run(input logic [NW-1:0] a, input logic [NW-1:0] b, input bit poke);
        logic [2*NW-1:0] exp;
        exp = {{NW{1'b0}}, a} * {{NW{1'b0}}, b};
        start = 1'b1; a_in = a; b_in = b;
        @(negedge clk);
        start = 1'b0; a_in = ~a; b_in = ~b;
        check(busy == 1'b1, "R5 busy after start", 64'(busy), 64'd1);
        for (int c = 1; c < 4; c++) begin
            if (poke && c == 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(prod_valid == 1'b0, "R3 early valid", 64'(prod_valid), 64'd0);
        end
        for (int k = 0; k < 2 * N; k++) begin
            @(negedge clk);
            check(prod_valid == 1'b1, "R4 consecutive valid", 64'(prod_valid), 64'd1);
            check(prod_word == exp[k*W +: W], "R2 R6 product word", 64'(prod_word), 64'(exp[k*W +: W]));
            check(prod_last == (k == 2 * N - 1), "R4 last flag", 64'(prod_last), 64'(k == 2 * N - 1));
        end
        @(negedge clk);
        check(prod_valid == 1'b0, "R5 no second stream", 64'(prod_valid), 64'd0);
        check(busy == 1'b0, "R5 busy released", 64'(busy), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        check(busy == 1'b0, "R1 busy at reset", 64'(busy), 64'd0);
        check(prod_valid == 1'b0, "R1 valid at reset", 64'(prod_valid), 64'd0);
        // R6 extremes; R7 each run restarts in the cycle busy falls
        run('0, '0, 1'b0);
        run('1, '1, 1'b0);
        run('1, '0, 1'b1);
        run({{(NW-W){1'b0}}, 16'h0001}, '1, 1'b0);
        run('1, {{(NW-W){1'b0}}, 16'hFFFF}, 1'b1);
        for (int t = 0; t < 24; t++) begin
            run(rnd_opnd(t % 2), rnd_opnd((t / 2) % 2), (t % 3) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule